// File: doc/BRIEF.md
# Interleaved Five-Bank Pixel Span Writer

This block takes a horizontal run of one to five adjacent pixels on a 1280-pixel scan line. It writes the whole run in a single cycle across five pixel memory banks. The banks are interleaved by column, so bank `b` holds every column whose index leaves remainder `b` when divided by five. Each bank therefore stores 256 pixels of every line, across 1024 lines.

A request carries a line number, a starting column, a pixel count, and five 32-bit pixel lanes. Lane 0 holds the pixel at the starting column, lane 1 the next column, and so on. The block works out which bank each lane lands in and rotates the lanes to match. It also gives every bank its own word address, because a bank whose index lies below the start column's remainder must take its pixel one word further along. The bank outputs are registered, and they appear one cycle after a request is accepted. A run that would go past the last column is refused: the error flag rises and no bank is written.

Top module: `pix_span_writer`

## Requirements
- R1: The pixel on lane i (bits `[32*i +: 32]` of `req_data`) leaves on the data lane of bank (req_x + i) mod 5, at bits `[32*b +: 32]` of `bank_data`.
- R2: An enabled bank b drives the word address line × 256 + floor((req_x + i) / 5), where i is the lane it received. The address is 18 bits wide at `bank_addr[18*b +: 18]`, with the line number in its upper 10 bits.
- R3: Bank b's write enable (`bank_we[b]`) is set exactly when some lane i < req_count maps to it. The number of enabled banks therefore equals req_count, and a count of zero enables none.
- R4: The request is refused if req_x + req_count > 1280 or req_count > 5. In that case `span_err` is 1 and every write enable is 0.
- R5: Outputs change in the cycle after a request is accepted (req_valid and req_ready both 1). A cycle with no accepted request is followed by all enables at 0 and `span_err` at 0.
- R6: While `rst` is high, req_ready, all enables and span_err are 0. req_ready is 1 from the first cycle after reset is released.
- R7: Runs that end exactly on column 1279 are accepted. Examples are a start of 1275 with five pixels and a start of 1279 with one pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_line | input | 10 | Scan line number |
| req_x | input | 11 | Starting column |
| req_count | input | 3 | Pixels in the run (0..5 legal) |
| req_data | input | 160 | Five pixel lanes, lane 0 at the starting column |
| bank_we | output | 5 | Per-bank write enable |
| bank_addr | output | 90 | Per-bank word address, 18 bits per bank |
| bank_data | output | 160 | Per-bank pixel word, 32 bits per bank |
| span_err | output | 1 | Last accepted run was refused |

## Verification
The bound checker watches four things on every cycle:
- a refused run never enables a bank;
- an idle cycle is followed by silent outputs;
- the number of enabled banks equals the count accepted one cycle earlier;
- every enabled bank's address carries the line number of that request.

Which bank gets which lane, and the step of one word for banks below the start remainder, are checked only by the bench. The bench sweeps every starting column with every count value and compares data and addresses against arithmetic expectations. That sweep includes the runs that end exactly on the last column, and starts beyond the line.

// File: rtl/psw_pkg.sv
package psw_pkg;
  // lane that feeds a given bank when the run starts at remainder 'phase'
  function automatic int lane_for_bank(input int bank, input int phase, input int nb);
    return (bank + nb - phase) % nb;
  endfunction
endpackage

// File: rtl/psw_span_decode.sv
module psw_span_decode #(
  parameter int NBANK  = 5,
  parameter int LINE_W = 1280,
  parameter int XW     = 11,
  parameter int CW     = 3,
  parameter int COLW   = 8,
  parameter int PW     = 3
) (
  input  logic [XW-1:0]    x_i,
  input  logic [CW-1:0]    count_i,
  output logic [PW-1:0]    phase_o,
  output logic [COLW-1:0]  col_o,
  output logic [NBANK-1:0] lane_mask_o,
  output logic             err_o
);
  always_comb begin
    phase_o = PW'(int'(x_i) % NBANK);
    col_o   = COLW'(int'(x_i) / NBANK);
    err_o   = (int'(x_i) + int'(count_i) > LINE_W) || (int'(count_i) > NBANK);
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_mask
    assign lane_mask_o[i] = (int'(count_i) > i);
  end
endmodule

// File: rtl/psw_lane_rotator.sv
module psw_lane_rotator #(
  parameter int NBANK = 5,
  parameter int PIX_W = 32,
  parameter int PW    = 3
) (
  input  logic [PW-1:0]          phase_i,
  input  logic [NBANK*PIX_W-1:0] lanes_i,
  input  logic [NBANK-1:0]       mask_i,
  output logic [NBANK*PIX_W-1:0] bank_data_o,
  output logic [NBANK-1:0]       bank_we_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [PIX_W-1:0] d;
    logic             w;
    always_comb begin
      d = '0;
      w = 1'b0;
      for (int l = 0; l < NBANK; l++) begin
        if (psw_pkg::lane_for_bank(b, int'(phase_i), NBANK) == l) begin
          d = lanes_i[l*PIX_W +: PIX_W];
          w = mask_i[l];
        end
      end
    end
    assign bank_data_o[b*PIX_W +: PIX_W] = d;
    assign bank_we_o[b] = w;
  end
endmodule

// File: rtl/psw_bank_addr.sv
module psw_bank_addr #(
  parameter int NBANK = 5,
  parameter int YW    = 10,
  parameter int COLW  = 8,
  parameter int PW    = 3,
  localparam int AW   = YW + COLW
) (
  input  logic [YW-1:0]       line_i,
  input  logic [COLW-1:0]     col_i,
  input  logic [PW-1:0]       phase_i,
  output logic [NBANK*AW-1:0] addr_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_addr
    logic [COLW-1:0] col_b;
    // banks below the start remainder take the next word in the line
    assign col_b = col_i + COLW'(int'(phase_i) > b);
    assign addr_o[b*AW +: AW] = {line_i, col_b};
  end
endmodule

// File: rtl/pix_span_writer.sv
module pix_span_writer #(
  parameter int  NBANK  = 5,
  parameter int  LINE_W = 1280,
  parameter int  NLINES = 1024,
  parameter int  PIX_W  = 32,
  localparam int XW     = $clog2(LINE_W),
  localparam int YW     = $clog2(NLINES),
  localparam int CW     = $clog2(NBANK + 1),
  localparam int COLW   = $clog2(LINE_W / NBANK),
  localparam int PW     = $clog2(NBANK),
  localparam int AW     = YW + COLW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [YW-1:0]          req_line,
  input  logic [XW-1:0]          req_x,
  input  logic [CW-1:0]          req_count,
  input  logic [NBANK*PIX_W-1:0] req_data,
  output logic [NBANK-1:0]       bank_we,
  output logic [NBANK*AW-1:0]    bank_addr,
  output logic [NBANK*PIX_W-1:0] bank_data,
  output logic                   span_err
);
  logic [PW-1:0]          phase_c;
  logic [COLW-1:0]        col_c;
  logic [NBANK-1:0]       mask_c;
  logic                   dec_err_c;
  logic                   err_c;
  logic [NBANK*PIX_W-1:0] data_c;
  logic [NBANK-1:0]       we_c;
  logic [NBANK*AW-1:0]    addr_c;
  logic                   accept;

  psw_span_decode #(
    .NBANK(NBANK), .LINE_W(LINE_W), .XW(XW), .CW(CW), .COLW(COLW), .PW(PW)
  ) u_dec (
    .x_i(req_x), .count_i(req_count), .phase_o(phase_c), .col_o(col_c),
    .lane_mask_o(mask_c), .err_o(dec_err_c)
  );

  psw_lane_rotator #(.NBANK(NBANK), .PIX_W(PIX_W), .PW(PW)) u_rot (
    .phase_i(phase_c), .lanes_i(req_data), .mask_i(mask_c),
    .bank_data_o(data_c), .bank_we_o(we_c)
  );

  psw_bank_addr #(.NBANK(NBANK), .YW(YW), .COLW(COLW), .PW(PW)) u_addr (
    .line_i(req_line), .col_i(col_c), .phase_i(phase_c), .addr_o(addr_c)
  );

  assign accept = req_valid && req_ready;
  assign err_c  = dec_err_c || (int'(req_line) >= NLINES);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      bank_we   <= '0;
      span_err  <= 1'b0;
      bank_addr <= '0;
      bank_data <= '0;
    end else begin
      req_ready <= 1'b1;
      bank_we   <= (accept && !err_c) ? we_c : '0;
      span_err  <= accept && err_c;
      bank_addr <= addr_c;
      bank_data <= data_c;
    end
  end
endmodule

// File: rtl/pix_span_writer_chk.sv
module pix_span_writer_chk #(
  parameter int  NBANK  = 5,
  parameter int  LINE_W = 1280,
  parameter int  NLINES = 1024,
  parameter int  PIX_W  = 32,
  localparam int YW     = $clog2(NLINES),
  localparam int CW     = $clog2(NBANK + 1),
  localparam int COLW   = $clog2(LINE_W / NBANK),
  localparam int AW     = YW + COLW
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic [YW-1:0]       req_line,
  input logic [CW-1:0]       req_count,
  input logic [NBANK-1:0]    bank_we,
  input logic [NBANK*AW-1:0] bank_addr,
  input logic                span_err
);
  // R4
  err_blocks_we_chk: assert property (@(posedge clk) disable iff (rst)
    span_err |-> (bank_we == '0));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid && req_ready) |-> (bank_we == '0 && !span_err));

  // R3
  we_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid && req_ready) && !span_err) |->
      ($countones(bank_we) == int'($past(req_count))));

  for (genvar b = 0; b < NBANK; b++) begin : g_line
    // R2
    line_field_chk: assert property (@(posedge clk) disable iff (rst)
      bank_we[b] |-> (bank_addr[b*AW+COLW +: YW] == $past(req_line)));
  end
endmodule

bind pix_span_writer pix_span_writer_chk #(
  .NBANK(NBANK), .LINE_W(LINE_W), .NLINES(NLINES), .PIX_W(PIX_W)
) u_chk (.*);

// File: tb/pix_span_writer_tb.sv
`timescale 1ns/1ps
module pix_span_writer_tb;
  localparam int NB = 5;
  localparam int PX = 32;
  localparam int AW = 18;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [9:0]     req_line = '0;
  logic [10:0]    req_x = '0;
  logic [2:0]     req_count = '0;
  logic [NB*PX-1:0] req_data = '0;
  logic [NB-1:0]  bank_we;
  logic [NB*AW-1:0] bank_addr;
  logic [NB*PX-1:0] bank_data;
  logic           span_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pix_span_writer u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_x(req_x), .req_count(req_count),
    .req_data(req_data), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_data(bank_data), .span_err(span_err)
  );

  function automatic logic [31:0] pix(input int x, input int i, input int ln);
    return 32'(x * 5003 + i * 977 + ln * 31 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one request; caller waits a cycle then calls verify
  task automatic drive(input int ln, input int x, input int c);
    req_valid = 1'b1;
    req_line  = 10'(ln);
    req_x     = 11'(x);
    req_count = 3'(c);
    for (int i = 0; i < NB; i++) req_data[i*PX +: PX] = pix(x, i, ln);
  endtask

  task automatic verify(input int ln, input int x, input int c);
    bit err;
    logic [NB-1:0] ewe;
    err = (x + c > 1280) || (c > 5);
    ewe = '0;
    chk(span_err == err, "R4 span_err", longint'(span_err), longint'(err));
    if (!err) begin
      for (int i = 0; i < c; i++) begin
        int b;
        b = (x + i) % NB;
        ewe[b] = 1'b1;
        // R1 lane-to-bank routing
        chk(bank_data[b*PX +: PX] == pix(x, i, ln), "R1 bank_data",
            longint'(bank_data[b*PX +: PX]), longint'(pix(x, i, ln)));
        // R2 / R7 per-bank address
        chk(bank_addr[b*AW +: AW] == AW'(ln * 256 + (x + i) / NB), "R2 bank_addr",
            longint'(bank_addr[b*AW +: AW]), longint'(ln * 256 + (x + i) / NB));
      end
    end
    // R3 enables (R4: none when refused)
    chk(bank_we == ewe, "R3 bank_we", longint'(bank_we), longint'(ewe));
  endtask

  task automatic one(input int ln, input int x, input int c);
    drive(ln, x, c);
    @(negedge clk);
    verify(ln, x, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(req_ready == 1'b0, "R6 ready in reset", longint'(req_ready), 0);
    chk(bank_we == '0 && !span_err, "R6 outputs in reset", longint'({bank_we, span_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 ready after reset", longint'(req_ready), 1);

    // R7 runs ending on the last column
    one(1023, 1275, 5);
    one(5, 1279, 1);
    one(6, 1279, 2);

    // sweep every start column with every count value
    for (int x = 0; x < 1280; x++)
      for (int c = 0; c < 8; c++)
        one((x * 3 + c * 101) % 1024, x, c);

    // starts beyond the line
    for (int x = 1280; x < 2048; x += 97)
      for (int c = 0; c < 6; c++)
        one(x % 1024, x, c);

    // R5 idle cycles are quiet even after a full run
    one(17, 40, 5);
    req_valid = 1'b0;
    @(negedge clk);
    chk(bank_we == '0 && !span_err, "R5 idle after request", longint'({bank_we, span_err}), 0);
    @(negedge clk);
    chk(bank_we == '0 && !span_err, "R5 idle second cycle", longint'({bank_we, span_err}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule